// File: doc/BRIEF.md
# Segmented Data Memory Access Router

This block sits on a processor's data-access port and sends each load or store to one of three places: on-chip RAM, the special-function-register (SFR) file, or an external memory bus. The choice depends on the address, on the addressing mode carried with the request, and on whether the data-segment register holds zero. Code space is separate and is never reached through this router.

Accesses to on-chip RAM and the SFR file finish one cycle after they are accepted. Accesses to external memory use a request/acknowledge handshake that can last any number of wait states. The router holds the request steady for that time and reports busy to the requester. The external address joins the segment register, as the upper byte, to the 16-bit offset.

Top module: `dmem_router`

## Requirements
- R1: A direct access (mode code 0) whose address lies in 0x400..0x7FF selects the SFR file, whatever the segment register holds. `sfr_addr` carries address bits [10:0].
- R2: A direct access below 0x400 selects on-chip RAM when the segment register is zero. When the segment register is non-zero it goes to external memory.
- R3: An indirect access (mode code 1) selects on-chip RAM only when the segment register is zero and the address is below RAM_BYTES (default 2048). Every other indirect access goes to external memory.
- R4: An explicit-external access (mode code 2) always goes to external memory, including addresses that overlap on-chip RAM or the SFR window.
- R5: The external address is {segment register, 16-bit address}, 24 bits wide. Write enable and write data pass to the selected target unchanged.
- R6: A RAM or SFR access asserts its select in the cycle the request is accepted. `rsp_done` pulses in the next cycle with the target's read data, or with zero for a write.
- R7: An external access raises `ext_req` in the cycle after acceptance and holds it, with a stable address, until `ext_ack`. `rsp_done` pulses in the cycle after `ext_ack`, with the `ext_rdata` value seen at acknowledge, or with zero for a write.
- R8: While an external access is pending, `req_busy` is high. A request presented during that time is refused: no target is selected and no response follows.
- R9: At most one of `ram_sel`, `sfr_sel` and `ext_req` is high in any cycle.
- R10: A direct access with any address bit above bit 10 set, or a request with the reserved mode code 3, selects no target. It answers in the next cycle with `rsp_done` and `rsp_err` both high and read data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 explicit external, 3 reserved |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| seg_reg | input | 8 | Current data-segment register |
| req_busy | output | 1 | External access pending; requests refused |
| rsp_done | output | 1 | Access complete pulse |
| rsp_err | output | 1 | Address error, valid with rsp_done |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| ram_sel | output | 1 | On-chip RAM select |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 16 | On-chip RAM byte address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, same cycle |
| sfr_sel | output | 1 | SFR file select |
| sfr_we | output | 1 | SFR write enable |
| sfr_addr | output | 11 | SFR byte address (direct bits [10:0]) |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, same cycle |
| ext_req | output | 1 | External access request, held until ack |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 24 | External address {segment, offset} |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 8 | External read data, valid with ext_ack |

## Verification
The hardest case to reach is a request that arrives during an external wait state. It must be refused and must leave nothing behind, even though its decode would select on-chip RAM. To reach it, the bench holds `ext_ack` low for several cycles after each external access and presents a RAM-bound request during that stall. It checks that no select appears. It then checks that the only response is the external one. The stimulus table also sets the segment-register and RAM-size boundaries side by side, so that one address lands on different targets.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_EXTERN   = 2'd2,
    MODE_RSVD     = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_SFR = 2'd1,
    TGT_EXT = 2'd2,
    TGT_ERR = 2'd3
  } acc_tgt_e;

endpackage

// File: rtl/dmem_router_rst_sync.sv
module dmem_router_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dmem_router_decode.sv
module dmem_router_decode
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEG_W     = 8,
  parameter int DIR_W     = 11,
  parameter int RAM_BYTES = 2048
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEG_W-1:0]  seg,
  output acc_tgt_e          tgt
);
  logic seg_zero;
  logic in_ram;
  logic dir_over;

  assign seg_zero = (seg == '0);
  assign in_ram   = ({{(32-ADDR_W){1'b0}}, addr} < RAM_BYTES);
  assign dir_over = |addr[ADDR_W-1:DIR_W];

  always_comb begin
    tgt = TGT_ERR;
    case (acc_mode_e'(mode))
      MODE_DIRECT: begin
        if (dir_over)                tgt = TGT_ERR;
        else if (addr[DIR_W-1])      tgt = TGT_SFR;
        else if (seg_zero && in_ram) tgt = TGT_RAM;
        else                         tgt = TGT_EXT;
      end
      MODE_INDIRECT: tgt = (seg_zero && in_ram) ? TGT_RAM : TGT_EXT;
      MODE_EXTERN:   tgt = TGT_EXT;
      default:       tgt = TGT_ERR;
    endcase
  end
endmodule

// File: rtl/dmem_router_ext.sv
module dmem_router_ext #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8,
  parameter int DATA_W = 8,
  localparam int XA_W  = ADDR_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [XA_W-1:0]   start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              pending,
  output logic              finish,
  output logic              pend_we,
  output logic              ext_req,
  output logic              ext_we,
  output logic [XA_W-1:0]   ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack
);
  typedef enum logic {ST_IDLE, ST_WAIT} ext_st_e;

  ext_st_e           st_q, st_d;
  logic              we_q;
  logic [XA_W-1:0]   addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    finish = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_WAIT;
        cap_en = 1'b1;
      end
      ST_WAIT: if (ext_ack) begin
        st_d   = ST_IDLE;
        finish = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      we_q    <= start_we;
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end
  end

  assign pending   = (st_q == ST_WAIT);
  assign pend_we   = we_q;
  assign ext_req   = pending;
  assign ext_we    = we_q;
  assign ext_addr  = addr_q;
  assign ext_wdata = wdata_q;

  // R7
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)));

  // R7
  ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> !ext_req);
endmodule

// File: rtl/dmem_router_resp.sv
module dmem_router_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_ram,
  input  logic              fire_sfr,
  input  logic              fire_ext,
  input  logic              fire_err,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              done_d, err_d;
  logic [DATA_W-1:0] rdata_d;
  logic              done_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    done_d  = fire_ram | fire_sfr | fire_ext | fire_err;
    err_d   = fire_err;
    rdata_d = '0;
    if (!acc_we) begin
      if (fire_ram)      rdata_d = ram_rdata;
      else if (fire_sfr) rdata_d = sfr_rdata;
      else if (fire_ext) rdata_d = ext_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  // R10
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_done && rsp_rdata == '0));
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEG_W     = 8,
  parameter int DATA_W    = 8,
  parameter int DIR_W     = 11,
  parameter int RAM_BYTES = 2048,
  localparam int XA_W     = ADDR_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [SEG_W-1:0]  seg_reg,
  output logic              req_busy,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              sfr_sel,
  output logic              sfr_we,
  output logic [DIR_W-1:0]  sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [XA_W-1:0]   ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata
);
  logic     rst_i_n;
  acc_tgt_e tgt;
  logic     accept;
  logic     go_ram, go_sfr, go_ext, go_err;
  logic     ext_pending, ext_finish, ext_pend_we;
  logic     rsp_we;

  dmem_router_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  dmem_router_decode #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .DIR_W(DIR_W), .RAM_BYTES(RAM_BYTES)
  ) u_dec (
    .mode(req_mode), .addr(req_addr), .seg(seg_reg), .tgt(tgt)
  );

  assign accept = req_valid && !ext_pending;
  assign go_ram = accept && (tgt == TGT_RAM);
  assign go_sfr = accept && (tgt == TGT_SFR);
  assign go_ext = accept && (tgt == TGT_EXT);
  assign go_err = accept && (tgt == TGT_ERR);

  assign ram_sel   = go_ram;
  assign ram_we    = go_ram && req_we;
  assign ram_addr  = req_addr;
  assign ram_wdata = req_wdata;

  assign sfr_sel   = go_sfr;
  assign sfr_we    = go_sfr && req_we;
  assign sfr_addr  = req_addr[DIR_W-1:0];
  assign sfr_wdata = req_wdata;

  dmem_router_ext #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .DATA_W(DATA_W)
  ) u_ext (
    .clk(clk), .rst_n(rst_i_n),
    .start(go_ext), .start_we(req_we),
    .start_addr({seg_reg, req_addr}), .start_wdata(req_wdata),
    .pending(ext_pending), .finish(ext_finish), .pend_we(ext_pend_we),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack)
  );

  assign req_busy = ext_pending;
  assign rsp_we   = ext_finish ? ext_pend_we : req_we;

  dmem_router_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_i_n),
    .fire_ram(go_ram), .fire_sfr(go_sfr), .fire_ext(ext_finish),
    .fire_err(go_err), .acc_we(rsp_we),
    .ram_rdata(ram_rdata), .sfr_rdata(sfr_rdata), .ext_rdata(ext_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({ram_sel, sfr_sel, ext_req}));

  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_busy |-> (!ram_sel && !sfr_sel && !rsp_err));

  // R1
  sfr_direct_only_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    sfr_sel |-> (req_mode == 2'd0 && req_addr >= 16'h0400 && req_addr <= 16'h07FF));

  // R6
  fast_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ram_sel || sfr_sel) |=> (rsp_done && !rsp_err));

  // R7
  ext_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ext_req && ext_ack) |=> (rsp_done && !rsp_err));

  // R4
  ext_mode_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && !req_busy && req_mode == 2'd2) |=> (ext_req && !rsp_done));
endmodule

// File: tb/dmem_router_tb.sv
module dmem_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  seg_reg = '0;
  logic        req_busy, rsp_done, rsp_err;
  logic [7:0]  rsp_rdata;
  logic        ram_sel, ram_we, sfr_sel, sfr_we, ext_req, ext_we;
  logic [15:0] ram_addr;
  logic [10:0] sfr_addr;
  logic [23:0] ext_addr;
  logic [7:0]  ram_wdata, sfr_wdata, ext_wdata;
  logic        ext_ack = 1'b0;
  logic [7:0]  ram_rdata, sfr_rdata, ext_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // target models, read data derived from the address presented
  assign ram_rdata = ram_addr[7:0] ^ 8'hA5;
  assign sfr_rdata = sfr_addr[7:0] ^ 8'h3C;
  assign ext_rdata = ext_addr[7:0] ^ 8'h5A;

  dmem_router u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .seg_reg(seg_reg), .req_busy(req_busy), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: mode(2) we(1) addr(16) seg(8) tgt(2: 0 ram 1 sfr 2 ext 3 err) wait(4)
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h0123, 8'h00, 2'd0, 4'd0},  // R2 direct low seg 0
    {2'd0, 1'b1, 16'h03FF, 8'h00, 2'd0, 4'd0},  // R2 top of low half, write
    {2'd0, 1'b0, 16'h03FF, 8'h01, 2'd2, 4'd2},  // R2 seg nonzero -> ext
    {2'd0, 1'b0, 16'h0400, 8'h00, 2'd1, 4'd0},  // R1 SFR base
    {2'd0, 1'b1, 16'h07FF, 8'h7E, 2'd1, 4'd0},  // R1 SFR top, seg nonzero
    {2'd1, 1'b0, 16'h0000, 8'h00, 2'd0, 4'd0},  // R3 indirect ram
    {2'd1, 1'b0, 16'h07FF, 8'h00, 2'd0, 4'd0},  // R3 last ram byte
    {2'd1, 1'b0, 16'h0800, 8'h00, 2'd2, 4'd3},  // R3 at RAM size -> ext
    {2'd1, 1'b1, 16'h0010, 8'h80, 2'd2, 4'd1},  // R3 seg nonzero -> ext write
    {2'd2, 1'b0, 16'h0020, 8'h00, 2'd2, 4'd0},  // R4 overlap with ram
    {2'd2, 1'b0, 16'h0500, 8'h00, 2'd2, 4'd4},  // R4 overlap with SFR window
    {2'd0, 1'b0, 16'h0800, 8'h00, 2'd3, 4'd0},  // R10 direct bit 11 set
    {2'd0, 1'b1, 16'h8400, 8'h00, 2'd3, 4'd0},  // R10 direct bit 15 set
    {2'd3, 1'b0, 16'h0001, 8'h00, 2'd3, 4'd0}   // R10 reserved mode
  };

  task automatic run_vec(input logic [32:0] v, input logic [7:0] wd);
    logic [1:0]  m   = v[32:31];
    logic        we  = v[30];
    logic [15:0] a   = v[29:14];
    logic [7:0]  s   = v[13:6];
    logic [1:0]  t   = v[5:4];
    int          w   = int'(v[3:0]);
    logic [7:0]  exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_we = we; req_addr = a;
    seg_reg = s; req_wdata = wd;
    #1;
    chk("R9 ram_sel", ram_sel, t == 2'd0);
    chk("R1 sfr_sel", sfr_sel, t == 2'd1);
    chk("R9 ext_req idle", ext_req, 1'b0);
    if (t == 2'd0) begin
      chk("R5 ram_we", ram_we, we);
      chk("R5 ram_addr", ram_addr, a);
      chk("R5 ram_wdata", ram_wdata, wd);
    end
    if (t == 2'd1) begin
      chk("R1 sfr_addr", sfr_addr, a[10:0]);
      chk("R5 sfr_we", sfr_we, we);
      chk("R5 sfr_wdata", sfr_wdata, wd);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (t == 2'd2) begin
      chk("R7 ext_req held", ext_req, 1'b1);
      chk("R5 ext_addr", ext_addr, {s, a});
      chk("R5 ext_we", ext_we, we);
      chk("R5 ext_wdata", ext_wdata, wd);
      chk("R8 busy", req_busy, 1'b1);
      chk("R7 no early done", rsp_done, 1'b0);
      for (int i = 0; i < w; i++) begin
        req_valid = 1'b1; req_mode = 2'd0; req_addr = 16'h0011; seg_reg = 8'h00;
        #1;
        chk("R8 refused ram_sel", ram_sel, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 no response while stalled", rsp_done, 1'b0);
        chk("R7 ext_addr stable", ext_addr, {s, a});
      end
      ext_ack = 1'b1;
      @(negedge clk);
      ext_ack = 1'b0;
      exp_rd = we ? 8'h00 : (a[7:0] ^ 8'h5A);
      chk("R7 ext done", rsp_done, 1'b1);
      chk("R7 ext rdata", rsp_rdata, exp_rd);
      chk("R7 ext no err", rsp_err, 1'b0);
      chk("R8 busy cleared", req_busy, 1'b0);
      @(negedge clk);
      chk("R8 no stray response", rsp_done, 1'b0);
    end else begin
      if (t == 2'd3)      exp_rd = 8'h00;
      else if (we)        exp_rd = 8'h00;
      else if (t == 2'd0) exp_rd = a[7:0] ^ 8'hA5;
      else                exp_rd = a[7:0] ^ 8'h3C;
      chk("R6 done", rsp_done, 1'b1);
      chk("R10 err flag", rsp_err, t == 2'd3);
      chk("R6 rdata", rsp_rdata, exp_rd);
      chk("R10 no ext started", ext_req, 1'b0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 reset done low", rsp_done, 1'b0);
        chk("R8 reset busy low", req_busy, 1'b0);
        chk("R9 reset ext_req low", ext_req, 1'b0);
        chk("R10 reset err low", rsp_err, 1'b0);
        for (int k = 0; k < NV; k++) run_vec(VEC[k], 8'(8'h40 + k));
        // R4: explicit external with seg nonzero, long wait
        run_vec({2'd2, 1'b1, 16'hFFFF, 8'hC3, 2'd2, 4'd9}, 8'h99);
        // R2: ext done and immediate follow-up RAM access, back to back
        run_vec({2'd0, 1'b0, 16'h0002, 8'h05, 2'd2, 4'd0}, 8'h00);
        run_vec({2'd0, 1'b0, 16'h0002, 8'h00, 2'd0, 4'd0}, 8'h00);
        // R8: ack while idle produces no response
        @(negedge clk); ext_ack = 1'b1;
        @(negedge clk); ext_ack = 1'b0;
        @(negedge clk);
        chk("R8 idle ack ignored", rsp_done, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule